// File: doc/BRIEF.md
# Two-Way Cache Victim Selector

This block decides which way of a two-way set-associative cache set takes a new line when an access misses. The cache controller sends a miss strobe with the set index and the valid, modified and lock bits of both ways. One cycle later the block reports the chosen way. It also reports whether that way holds modified data that must first go to a copyback holding buffer, or that no way can be replaced because both are locked. The result stays on the outputs until the controller acknowledges it.

The block keeps one recency bit per set in an internal register array. The controller reports every hit and every completed fill with a touch strobe, the set and the way that was touched. Tag comparison, data storage, bus traffic and the copyback itself belong to other blocks.

Top module: `repl_way_sel`

## Requirements
- R1: After reset `sel_vld` is low, and the recency bit of every set names way 0 as least recently used. A first miss in any set with both ways valid and unlocked therefore picks way 0.
- R2: An unlocked invalid way is always picked ahead of any valid way.
- R3: When both ways are invalid and unlocked, way 0 is picked.
- R4: When both ways are valid and unlocked, the way named by the set's recency bit is picked (0 = way 0, 1 = way 1).
- R5: A touch of way w in set s sets that set's recency bit to name the other way. The bits of all other sets are unchanged.
- R6: A locked way is never picked. If exactly one way is locked, the other way is picked whatever the recency bit says.
- R7: When both ways are locked, `sel_none` is high and `sel_way` and `sel_copyback` are low. `sel_none` is low in every other case.
- R8: `sel_copyback` is high exactly when the picked way is both valid and modified. A modified bit on an invalid way has no effect.
- R9: A miss strobe taken while no result is pending produces `sel_vld` high in the next cycle. The result outputs then stay unchanged until an acknowledge, and miss strobes that arrive while a result is pending are ignored.
- R10: `sel_ack` while `sel_vld` is high drops `sel_vld` in the next cycle.
- R11: If a touch and a miss hit the same set in the same cycle, the pick uses the recency bit as it stood before that touch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| miss_req | input | 1 | Miss strobe asking for a victim pick |
| miss_set | input | SET_W | Set index of the miss |
| way_valid | input | 2 | Valid bit per way of the missing set |
| way_dirty | input | 2 | Modified bit per way of the missing set |
| way_lock | input | 2 | Lock bit per way of the missing set |
| sel_ack | input | 1 | Requester acknowledges the pending result |
| touch_en | input | 1 | A hit or a fill happened in the cache |
| touch_set | input | SET_W | Set index of that hit or fill |
| touch_way | input | 1 | Way of that hit or fill |
| sel_vld | output | 1 | A pick result is pending |
| sel_way | output | 1 | Picked way |
| sel_copyback | output | 1 | Picked way is valid and modified and must be copied back |
| sel_none | output | 1 | Both ways locked, so no way can be replaced |

## Verification
The checker captures the input bits on each accepted miss and then checks every cycle that a pending result never names a locked way. It also checks that an invalid way beats a valid one, that a double-invalid tie goes to way 0, that the no-victim and copyback flags agree with the captured bits, and that results hold until acknowledged and clear afterwards. The recency side cannot be seen by a per-cycle property, because it depends on the history of touches. This covers the reset value, the per-set update, independence between sets and the ordering of a touch and a miss in the same cycle. Only the bench shows these, by sweeping every valid, modified and lock pattern against both recency values in every set.

// File: rtl/repl_pkg.sv
package repl_pkg;

  // Result of one victim pick for a two-way set.
  typedef struct packed {
    logic none;      // no replaceable way
    logic way;       // picked way
    logic copyback;  // picked way holds modified valid data
  } repl_verdict_t;

endpackage

// File: rtl/repl_lru_store.sv
module repl_lru_store #(
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic             upd_way,
  input  logic [SET_W-1:0] rd_set,
  output logic             rd_lru
);

  localparam int NUM_SETS = 1 << SET_W;

  logic [NUM_SETS-1:0] lru_q;
  logic [NUM_SETS-1:0] lru_d;
  logic [NUM_SETS-1:0] lru_we;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    // next state: point at the way that was not touched
    always_comb begin
      lru_we[s] = upd_en && (upd_set == SET_W'(s));
      lru_d[s]  = ~upd_way;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lru_q[s] <= 1'b0;
      end else if (lru_we[s]) begin
        lru_q[s] <= lru_d[s];
      end
    end
  end

  assign rd_lru = lru_q[rd_set];

endmodule

// File: rtl/repl_victim_pick.sv
module repl_victim_pick
  import repl_pkg::*;
(
  input  logic [1:0]    valid_i,
  input  logic [1:0]    dirty_i,
  input  logic [1:0]    lock_i,
  input  logic          lru_i,
  output repl_verdict_t verdict_o
);

  logic [1:0] cand;
  logic [1:0] fresh;

  always_comb begin
    cand      = ~lock_i;
    fresh     = cand & ~valid_i;
    verdict_o = '0;
    if (fresh[0]) begin
      verdict_o.way = 1'b0;
    end else if (fresh[1]) begin
      verdict_o.way = 1'b1;
    end else if (&cand) begin
      verdict_o.way = lru_i;
    end else if (cand[0]) begin
      verdict_o.way = 1'b0;
    end else if (cand[1]) begin
      verdict_o.way = 1'b1;
    end else begin
      verdict_o.none = 1'b1;
    end
    verdict_o.copyback = ~verdict_o.none
                         & valid_i[verdict_o.way]
                         & dirty_i[verdict_o.way];
  end

endmodule

// File: rtl/repl_result_reg.sv
module repl_result_reg
  import repl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          ack_i,
  input  repl_verdict_t verdict_i,
  output logic          vld_o,
  output repl_verdict_t verdict_o
);

  logic          vld_q;
  logic          vld_d;
  logic          take;
  logic          drop;
  repl_verdict_t data_q;

  always_comb begin
    take  = req_i && !vld_q;
    drop  = vld_q && ack_i;
    vld_d = take || (vld_q && !drop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (take) begin
      data_q <= verdict_i;
    end
  end

  assign vld_o     = vld_q;
  assign verdict_o = data_q;

endmodule

// File: rtl/repl_way_sel.sv
module repl_way_sel
  import repl_pkg::*;
#(
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_req,
  input  logic [SET_W-1:0] miss_set,
  input  logic [1:0]       way_valid,
  input  logic [1:0]       way_dirty,
  input  logic [1:0]       way_lock,
  input  logic             sel_ack,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic             touch_way,
  output logic             sel_vld,
  output logic             sel_way,
  output logic             sel_copyback,
  output logic             sel_none
);

  logic          set_lru;
  repl_verdict_t pick;
  repl_verdict_t held;

  repl_lru_store #(.SET_W(SET_W)) lru_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (touch_en),
    .upd_set (touch_set),
    .upd_way (touch_way),
    .rd_set  (miss_set),
    .rd_lru  (set_lru)
  );

  repl_victim_pick pick_i (
    .valid_i   (way_valid),
    .dirty_i   (way_dirty),
    .lock_i    (way_lock),
    .lru_i     (set_lru),
    .verdict_o (pick)
  );

  repl_result_reg res_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (miss_req),
    .ack_i     (sel_ack),
    .verdict_i (pick),
    .vld_o     (sel_vld),
    .verdict_o (held)
  );

  assign sel_way      = held.way;
  assign sel_copyback = held.copyback;
  assign sel_none     = held.none;

endmodule

// File: rtl/repl_way_sel_chk.sv
module repl_way_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       miss_req,
  input logic [1:0] way_valid,
  input logic [1:0] way_dirty,
  input logic [1:0] way_lock,
  input logic       sel_ack,
  input logic       sel_vld,
  input logic       sel_way,
  input logic       sel_copyback,
  input logic       sel_none
);

  logic [1:0] cap_valid;
  logic [1:0] cap_dirty;
  logic [1:0] cap_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 2'b00;
      cap_dirty <= 2'b00;
      cap_lock  <= 2'b00;
    end else if (miss_req && !sel_vld) begin
      cap_valid <= way_valid;
      cap_dirty <= way_dirty;
      cap_lock  <= way_lock;
    end
  end

  p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req && !sel_vld |=> sel_vld);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld && !sel_ack |=> sel_vld && $stable(sel_way) && $stable(sel_none)
                            && $stable(sel_copyback));

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld && sel_ack |=> !sel_vld);

  p_no_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld && !sel_none |-> !cap_lock[sel_way]);

  p_invalid_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld && !sel_none && cap_valid[sel_way] |-> ((~cap_valid & ~cap_lock) == 2'b00));

  p_tie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld && (cap_valid == 2'b00) && (cap_lock == 2'b00) |-> !sel_none && !sel_way);

  p_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld |-> (sel_none == (&cap_lock)));

  p_none_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld && sel_none |-> !sel_way && !sel_copyback);

  p_copyback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld && !sel_none |-> sel_copyback == (cap_valid[sel_way] && cap_dirty[sel_way]));

endmodule

bind repl_way_sel repl_way_sel_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .miss_req     (miss_req),
  .way_valid    (way_valid),
  .way_dirty    (way_dirty),
  .way_lock     (way_lock),
  .sel_ack      (sel_ack),
  .sel_vld      (sel_vld),
  .sel_way      (sel_way),
  .sel_copyback (sel_copyback),
  .sel_none     (sel_none)
);

// File: tb/repl_way_sel_tb_top.sv
`timescale 1ns/1ps
module repl_way_sel_tb_top;

  localparam int SET_W = 3;
  localparam int NS    = 1 << SET_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             miss_req;
  logic [SET_W-1:0] miss_set;
  logic [1:0]       way_valid;
  logic [1:0]       way_dirty;
  logic [1:0]       way_lock;
  logic             sel_ack;
  logic             touch_en;
  logic [SET_W-1:0] touch_set;
  logic             touch_way;
  logic             sel_vld;
  logic             sel_way;
  logic             sel_copyback;
  logic             sel_none;

  int n_chk  = 0;
  int n_fail = 0;
  logic lru_m [NS];

  always #4 clk = ~clk;

  repl_way_sel #(.SET_W(SET_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_set(miss_set),
    .way_valid(way_valid), .way_dirty(way_dirty), .way_lock(way_lock),
    .sel_ack(sel_ack), .touch_en(touch_en), .touch_set(touch_set),
    .touch_way(touch_way), .sel_vld(sel_vld), .sel_way(sel_way),
    .sel_copyback(sel_copyback), .sel_none(sel_none)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Score model: invalid=0, valid LRU=1, valid MRU=2; lowest unlocked wins, tie to way 0.
  task automatic model(input logic [1:0] v, input logic [1:0] d, input logic [1:0] l,
                       input logic lru, output logic w, output logic none, output logic cb);
    int best = 3;
    w = 1'b0; none = 1'b1;
    for (int k = 0; k < 2; k++) begin
      if (!l[k]) begin
        int sc = !v[k] ? 0 : ((int'(lru) == k) ? 1 : 2);
        if (sc < best) begin best = sc; w = k[0]; none = 1'b0; end
      end
    end
    cb = !none && v[w] && d[w];
  endtask

  task automatic touch(input int s, input logic w);
    @(negedge clk);
    touch_en = 1'b1; touch_set = SET_W'(s); touch_way = w;
    @(posedge clk);
    @(negedge clk);
    touch_en = 1'b0;
    lru_m[s] = ~w;
  endtask

  // Issue a miss (optionally with a same-cycle touch), check result, hold and release.
  task automatic miss(input string req, input int s, input logic [1:0] v,
                      input logic [1:0] d, input logic [1:0] l,
                      input logic with_touch, input logic tw);
    logic ew, en, ec;
    model(v, d, l, lru_m[s], ew, en, ec);
    @(negedge clk);
    miss_req = 1'b1; miss_set = SET_W'(s);
    way_valid = v; way_dirty = d; way_lock = l;
    if (with_touch) begin touch_en = 1'b1; touch_set = SET_W'(s); touch_way = tw; end
    @(posedge clk);
    @(negedge clk);
    miss_req = 1'b0; touch_en = 1'b0;
    if (with_touch) lru_m[s] = ~tw;
    chk("R9", "sel_vld", sel_vld, 1'b1);
    chk(req, "sel_way", sel_way, ew);
    chk(en ? "R7" : req, "sel_none", sel_none, en);
    chk("R8", "sel_copyback", sel_copyback, ec);
    // pending: a new, different miss must be ignored
    miss_req = 1'b1; miss_set = SET_W'(s + 1);
    way_valid = ~v; way_dirty = ~d; way_lock = ~l;
    @(posedge clk);
    @(negedge clk);
    miss_req = 1'b0;
    chk("R9", "held sel_way", sel_way, ew);
    chk("R9", "held sel_none", sel_none, en);
    chk("R9", "held sel_copyback", sel_copyback, ec);
    sel_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sel_ack = 1'b0;
    chk("R10", "sel_vld after ack", sel_vld, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; miss_req = 1'b0; miss_set = '0; way_valid = '0; way_dirty = '0;
    way_lock = '0; sel_ack = 1'b0; touch_en = 1'b0; touch_set = '0; touch_way = 1'b0;
    for (int s = 0; s < NS; s++) lru_m[s] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sel_vld after reset", sel_vld, 1'b0);

    // R1: reset recency names way 0 in every set
    for (int s = 0; s < NS; s++) miss("R1", s, 2'b11, 2'b00, 2'b00, 1'b0, 1'b0);

    // R2 R3 R4 R6 R7 R8: every bit pattern against both recency values, every set
    for (int s = 0; s < NS; s++) begin
      for (int r = 0; r < 2; r++) begin
        touch(s, r[0] ? 1'b0 : 1'b1);
        for (int c = 0; c < 64; c++) begin
          logic [5:0] p = 6'(c);
          string req;
          if (p[5:4] != 2'b00) req = "R6";
          else if (p[1:0] == 2'b00) req = "R3";
          else if (p[1:0] == 2'b11) req = "R4";
          else req = "R2";
          miss(req, s, p[1:0], p[3:2], p[5:4], 1'b0, 1'b0);
        end
      end
    end

    // R5: per-set update, other sets untouched
    for (int s = 0; s < NS; s++) touch(s, s[0]);
    touch(2, 1'b0);
    for (int s = 0; s < NS; s++) miss("R5", s, 2'b11, 2'b00, 2'b00, 1'b0, 1'b0);

    // R11: touch and miss in the same cycle use the old recency bit
    for (int s = 0; s < NS; s++) begin
      miss("R11", s, 2'b11, 2'b11, 2'b00, 1'b1, lru_m[s]);
      miss("R11", s, 2'b11, 2'b01, 2'b00, 1'b0, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule